// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks the pre-divider and feedback divider settings of a PLL so that its output comes as close as possible to a requested lane rate. A request supplies a reference frequency and a lane rate, both in Hz. The engine doubles the lane rate to get the target VCO frequency. It then walks the pre-divider upward through every value that keeps the comparison frequency (reference divided by pre-divider) inside a 5 MHz to 40 MHz window. For each pre-divider it derives a feedback divider and drops settings the PLL cannot use. It keeps the setting whose achieved VCO frequency has the smallest error.

All multiplications and divisions run on shared iterative units, one bit per cycle, at 64-bit precision. The search therefore takes a few hundred cycles per pre-divider value. A one-cycle start pulse launches a search. A one-cycle done pulse ends it and publishes the results. If no legal setting exists, the found flag and the reported rate are zero and the divider outputs keep their earlier values.

Top module: `pll_ratio_finder`

## Requirements
- R1: A start pulse while the engine is idle is accepted, and busy is high from the next cycle. A start pulse while busy is ignored: the results of the running search are the ones published, and no extra done pulse occurs.
- R2: The target VCO frequency is 2 × lane rate. For each pre-divider p the feedback divider is floor(target × p / fref).
- R3: Pre-divider values are tried in increasing order from ceiling(fref / 40 MHz) to floor(fref / 5 MHz), never below 1. When this range is empty (for example fref below 5 MHz, or zero), no candidate exists.
- R4: A feedback divider is legal only when it lies in 12..511 and is not 15. Both ends of the range are inclusive.
- R5: The error of a legal candidate is |target − floor(fbdiv × fref / p)|. A candidate replaces the best so far only when its error is strictly smaller, so on equal error the lower pre-divider is kept.
- R6: At the end of a search, done is high for exactly one cycle and busy falls in that cycle. found is 1 when at least one legal candidate existed. In that case prediv, fbdiv and rate (best VCO frequency / 2, rounded down) take the winner's values.
- R7: When no legal candidate exists, found is 0 and rate is 0 at done, and prediv and fbdiv keep the values they had before the search.
- R8: After reset, busy, done and found are 0 and prediv, fbdiv and rate are 0.
- R9: A start pulse in the same cycle that done is high is accepted as a new search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a search |
| fref_i | input | 32 | Reference frequency in Hz, sampled with start |
| rate_i | input | 32 | Requested lane rate in Hz, sampled with start |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse when results are published |
| found_o | output | 1 | Last search found a legal setting |
| prediv_o | output | 10 | Chosen pre-divider |
| fbdiv_o | output | 9 | Chosen feedback divider |
| rate_o | output | 32 | Achieved lane rate in Hz, zero if nothing was found |

## Verification
Publishing a finished result and accepting the next request can happen in the same cycle. The done pulse coincides with the return to idle, so a start driven in the done cycle must launch the second search without disturbing the first result. The bench provokes this by issuing the second request in the very cycle it sees done. It judges the case by comparing both published results, in order, with its own model and by seeing busy rise one cycle later. A start pulse injected mid-search must change neither the published values nor the count of done pulses.

// File: rtl/pll_ratio_pkg.sv
package pll_ratio_pkg;

    // sweep controller states
    typedef enum logic [2:0] {
        S_IDLE,
        S_LO,
        S_HI,
        S_MUL_FB,
        S_DIV_FB,
        S_MUL_VCO,
        S_DIV_VCO
    } srch_state_e;

endpackage

// File: rtl/pll_seq_mul.sv
module pll_seq_mul #(
    parameter int unsigned A_W = 64,
    parameter int unsigned B_W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    output logic           done_o,
    output logic [A_W-1:0] prod_o
);

    localparam int unsigned CNT_W = $clog2(B_W + 1);

    typedef struct packed {
        logic [A_W-1:0]   acc;
        logic [A_W-1:0]   mcand;
        logic [B_W-1:0]   mplier;
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             done;
    } mul_ctx_t;

    mul_ctx_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start_i) begin
            d.acc    = '0;
            d.mcand  = a_i;
            d.mplier = b_i;
            d.cnt    = CNT_W'(B_W);
            d.run    = 1'b1;
        end else if (q.run) begin
            if (q.mplier[0]) begin
                d.acc = q.acc + q.mcand;
            end
            d.mcand  = q.mcand << 1;
            d.mplier = q.mplier >> 1;
            d.cnt    = q.cnt - CNT_W'(1);
            if (q.cnt == CNT_W'(1)) begin
                d.run  = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign prod_o = q.acc;

endmodule

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
    parameter int unsigned N_W = 64,
    parameter int unsigned D_W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [N_W-1:0] num_i,
    input  logic [D_W-1:0] den_i,
    output logic           done_o,
    output logic [N_W-1:0] quot_o
);

    localparam int unsigned CNT_W = $clog2(N_W + 1);

    typedef struct packed {
        logic [N_W-1:0]   quo;
        logic [D_W:0]     rem;
        logic [D_W-1:0]   den;
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             done;
    } div_ctx_t;

    div_ctx_t q, d;
    logic [D_W:0] shifted;
    logic         qbit;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        shifted = {q.rem[D_W-1:0], q.quo[N_W-1]};
        qbit    = 1'b0;
        if (start_i) begin
            d.quo = num_i;
            d.rem = '0;
            d.den = den_i;
            d.cnt = CNT_W'(N_W);
            d.run = 1'b1;
        end else if (q.run) begin
            if (shifted >= {1'b0, q.den}) begin
                d.rem = shifted - {1'b0, q.den};
                qbit  = 1'b1;
            end else begin
                d.rem = shifted;
            end
            d.quo = {q.quo[N_W-2:0], qbit};
            d.cnt = q.cnt - CNT_W'(1);
            if (q.cnt == CNT_W'(1)) begin
                d.run  = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign quot_o = q.quo;

endmodule

// File: rtl/pll_ratio_finder.sv
module pll_ratio_finder #(
    parameter int unsigned FREQ_W     = 32,
    parameter int unsigned PROD_W     = 64,
    parameter int unsigned PREDIV_W   = 10,
    parameter int unsigned FBDIV_W    = 9,
    parameter int unsigned CMP_MIN_HZ = 5_000_000,
    parameter int unsigned CMP_MAX_HZ = 40_000_000,
    parameter int unsigned FB_LO      = 12,
    parameter int unsigned FB_HI      = 511,
    parameter int unsigned FB_GAP     = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [FREQ_W-1:0]   fref_i,
    input  logic [FREQ_W-1:0]   rate_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                found_o,
    output logic [PREDIV_W-1:0] prediv_o,
    output logic [FBDIV_W-1:0]  fbdiv_o,
    output logic [FREQ_W-1:0]   rate_o
);

    import pll_ratio_pkg::*;

    localparam int unsigned OPB_W = (PREDIV_W > FBDIV_W) ? PREDIV_W : FBDIV_W;
    localparam logic [PROD_W-1:0] PRE_CAP = PROD_W'((64'd1 << PREDIV_W) - 64'd1);

    typedef struct packed {
        srch_state_e          st;
        logic [PROD_W-1:0]    target;
        logic [FREQ_W-1:0]    fref;
        logic [PREDIV_W-1:0]  pre;
        logic [PREDIV_W-1:0]  pre_max;
        logic [FBDIV_W-1:0]   fb_cur;
        logic [PROD_W-1:0]    best_err;
        logic [PROD_W-1:0]    best_vco;
        logic [PREDIV_W-1:0]  best_pre;
        logic [FBDIV_W-1:0]   best_fb;
        logic                 any;
        logic                 mul_go;
        logic [PROD_W-1:0]    mul_a;
        logic [OPB_W-1:0]     mul_b;
        logic                 div_go;
        logic [PROD_W-1:0]    div_n;
        logic [FREQ_W-1:0]    div_d;
        logic                 done;
        logic                 found;
        logic [PREDIV_W-1:0]  pre_o;
        logic [FBDIV_W-1:0]   fb_o;
        logic [FREQ_W-1:0]    rate_o;
    } ctx_t;

    ctx_t q, d;

    logic              mul_done, div_done;
    logic [PROD_W-1:0] mul_prod, div_quot;
    logic [PROD_W-1:0] err_now;

    pll_seq_mul #(
        .A_W (PROD_W),
        .B_W (OPB_W)
    ) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (q.mul_go),
        .a_i     (q.mul_a),
        .b_i     (q.mul_b),
        .done_o  (mul_done),
        .prod_o  (mul_prod)
    );

    pll_seq_div #(
        .N_W (PROD_W),
        .D_W (FREQ_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (q.div_go),
        .num_i   (q.div_n),
        .den_i   (q.div_d),
        .done_o  (div_done),
        .quot_o  (div_quot)
    );

    // clamp a quotient into the pre-divider range
    function automatic logic [PREDIV_W-1:0] clamp_pre(input logic [PROD_W-1:0] v);
        return (v > PRE_CAP) ? PRE_CAP[PREDIV_W-1:0] : v[PREDIV_W-1:0];
    endfunction

    function automatic logic fb_legal(input logic [PROD_W-1:0] v);
        return (v >= PROD_W'(FB_LO)) && (v <= PROD_W'(FB_HI)) && (v != PROD_W'(FB_GAP));
    endfunction

    // publish the outcome of the sweep
    function automatic ctx_t wrap_up(input ctx_t c);
        ctx_t r;
        r       = c;
        r.done  = 1'b1;
        r.st    = S_IDLE;
        r.found = c.any;
        if (c.any) begin
            r.pre_o  = c.best_pre;
            r.fb_o   = c.best_fb;
            r.rate_o = FREQ_W'(c.best_vco >> 1);
        end else begin
            r.rate_o = '0;
        end
        return r;
    endfunction

    // step to the next pre-divider or finish
    function automatic ctx_t move_on(input ctx_t c);
        ctx_t r;
        r = c;
        if (c.pre == c.pre_max) begin
            r = wrap_up(c);
        end else begin
            r.pre    = c.pre + PREDIV_W'(1);
            r.mul_go = 1'b1;
            r.mul_a  = c.target;
            r.mul_b  = OPB_W'(c.pre + PREDIV_W'(1));
            r.st     = S_MUL_FB;
        end
        return r;
    endfunction

    always_comb begin
        logic [PREDIV_W-1:0] lo_v;
        logic [PREDIV_W-1:0] hi_v;
        d        = q;
        d.done   = 1'b0;
        d.mul_go = 1'b0;
        d.div_go = 1'b0;
        err_now  = (q.target >= div_quot) ? (q.target - div_quot) : (div_quot - q.target);
        lo_v     = clamp_pre(div_quot);
        hi_v     = clamp_pre(div_quot);
        unique case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.fref     = fref_i;
                    d.target   = PROD_W'(rate_i) << 1;
                    d.any      = 1'b0;
                    d.best_err = '1;
                    d.div_go   = 1'b1;
                    d.div_n    = PROD_W'(fref_i) + PROD_W'(CMP_MAX_HZ - 1);
                    d.div_d    = FREQ_W'(CMP_MAX_HZ);
                    d.st       = S_LO;
                end
            end
            S_LO: begin
                if (div_done) begin
                    d.pre    = (lo_v == '0) ? PREDIV_W'(1) : lo_v;
                    d.div_go = 1'b1;
                    d.div_n  = PROD_W'(q.fref);
                    d.div_d  = FREQ_W'(CMP_MIN_HZ);
                    d.st     = S_HI;
                end
            end
            S_HI: begin
                if (div_done) begin
                    d.pre_max = hi_v;
                    if (q.pre > hi_v) begin
                        d = wrap_up(d);
                    end else begin
                        d.mul_go = 1'b1;
                        d.mul_a  = q.target;
                        d.mul_b  = OPB_W'(q.pre);
                        d.st     = S_MUL_FB;
                    end
                end
            end
            S_MUL_FB: begin
                if (mul_done) begin
                    d.div_go = 1'b1;
                    d.div_n  = mul_prod;
                    d.div_d  = q.fref;
                    d.st     = S_DIV_FB;
                end
            end
            S_DIV_FB: begin
                if (div_done) begin
                    if (fb_legal(div_quot)) begin
                        d.fb_cur = div_quot[FBDIV_W-1:0];
                        d.mul_go = 1'b1;
                        d.mul_a  = PROD_W'(q.fref);
                        d.mul_b  = OPB_W'(div_quot[FBDIV_W-1:0]);
                        d.st     = S_MUL_VCO;
                    end else begin
                        d = move_on(d);
                    end
                end
            end
            S_MUL_VCO: begin
                if (mul_done) begin
                    d.div_go = 1'b1;
                    d.div_n  = mul_prod;
                    d.div_d  = FREQ_W'(q.pre);
                    d.st     = S_DIV_VCO;
                end
            end
            S_DIV_VCO: begin
                if (div_done) begin
                    if (err_now < q.best_err) begin
                        d.best_err = err_now;
                        d.best_vco = div_quot;
                        d.best_pre = q.pre;
                        d.best_fb  = q.fb_cur;
                        d.any      = 1'b1;
                    end
                    d = move_on(d);
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o   = (q.st != S_IDLE);
    assign done_o   = q.done;
    assign found_o  = q.found;
    assign prediv_o = q.pre_o;
    assign fbdiv_o  = q.fb_o;
    assign rate_o   = q.rate_o;

endmodule

// File: rtl/pll_ratio_finder_chk.sv
module pll_ratio_finder_chk #(
    parameter int unsigned FREQ_W   = 32,
    parameter int unsigned PREDIV_W = 10,
    parameter int unsigned FBDIV_W  = 9,
    parameter int unsigned FB_LO    = 12,
    parameter int unsigned FB_HI    = 511,
    parameter int unsigned FB_GAP   = 15
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                busy_o,
    input logic                done_o,
    input logic                found_o,
    input logic [PREDIV_W-1:0] prediv_o,
    input logic [FBDIV_W-1:0]  fbdiv_o,
    input logic [FREQ_W-1:0]   rate_o
);

    a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    a_r1_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ($stable(prediv_o) && $stable(fbdiv_o) && $stable(rate_o) && $stable(found_o)));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r6_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    a_r4_fb_legal: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> ((fbdiv_o >= FBDIV_W'(FB_LO)) && (fbdiv_o <= FBDIV_W'(FB_HI))
                     && (fbdiv_o != FBDIV_W'(FB_GAP))));

    a_r3_prediv_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> (prediv_o != '0));

    a_r7_empty_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !found_o) |-> ((rate_o == '0) && $stable(prediv_o) && $stable(fbdiv_o)));

endmodule

bind pll_ratio_finder pll_ratio_finder_chk #(
    .FREQ_W   (FREQ_W),
    .PREDIV_W (PREDIV_W),
    .FBDIV_W  (FBDIV_W),
    .FB_LO    (FB_LO),
    .FB_HI    (FB_HI),
    .FB_GAP   (FB_GAP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .found_o  (found_o),
    .prediv_o (prediv_o),
    .fbdiv_o  (fbdiv_o),
    .rate_o   (rate_o)
);

// File: tb/pll_ratio_finder_tb.sv
module pll_ratio_finder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] fref_i = '0;
    logic [31:0] rate_i = '0;
    logic        busy_o, done_o, found_o;
    logic [9:0]  prediv_o;
    logic [8:0]  fbdiv_o;
    logic [31:0] rate_o;

    int total = 0;
    int bad = 0;
    int issued = 0;
    int dones = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [9:0]  pre;
        logic [8:0]  fb;
        logic [31:0] rate;
        logic        found;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    logic [9:0] held_pre = '0;
    logic [8:0] held_fb = '0;

    always #2 clk = ~clk;   // 250 MHz

    pll_ratio_finder u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .fref_i(fref_i), .rate_i(rate_i),
        .busy_o(busy_o), .done_o(done_o), .found_o(found_o),
        .prediv_o(prediv_o), .fbdiv_o(fbdiv_o), .rate_o(rate_o)
    );

    task automatic check(input string tag, input string what, input longint unsigned got,
                         input longint unsigned exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, exp);
        end
    endtask

    // reference model built from R2..R7
    function automatic exp_t model(input longint unsigned fref, input longint unsigned rate,
                                   input string tag);
        exp_t e;
        longint unsigned tgt, lo, hi, fb, vco, err, best_err, best_vco;
        longint unsigned best_p, best_fb;
        bit any;
        tgt = rate * 2;
        lo = (fref + 64'd39_999_999) / 64'd40_000_000;
        if (lo < 1) lo = 1;
        if (lo > 1023) lo = 1023;
        hi = fref / 64'd5_000_000;
        if (hi > 1023) hi = 1023;
        any = 1'b0;
        best_err = '1;
        best_vco = 0;
        best_p = 0;
        best_fb = 0;
        for (longint unsigned p = lo; p <= hi; p++) begin
            fb = (tgt * p) / fref;
            if (fb < 12 || fb == 15 || fb > 511) continue;
            vco = (fb * fref) / p;
            err = (tgt >= vco) ? tgt - vco : vco - tgt;
            if (err < best_err) begin
                best_err = err; best_vco = vco; best_p = p; best_fb = fb; any = 1'b1;
            end
        end
        e.tag = tag;
        e.found = any;
        if (any) begin
            held_pre = best_p[9:0];
            held_fb = best_fb[8:0];
            e.rate = best_vco[32:1];
        end else begin
            e.rate = '0;
        end
        e.pre = held_pre;
        e.fb = held_fb;
        return e;
    endfunction

    // driver: called at a negedge; drives a one-cycle start and pushes the expectation
    task automatic issue(input longint unsigned fref, input longint unsigned rate,
                         input string tag);
        fref_i = fref[31:0];
        rate_i = rate[31:0];
        start_i = 1'b1;
        exp_q.push_back(model(fref, rate, tag));
        issued++;
        @(negedge clk);
        start_i = 1'b0;
        check({tag, " R1"}, "busy after start", busy_o, 1);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done_o);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            exp_t e;
            dones++;
            check("R6", "busy low at done", busy_o, 0);
            if (exp_q.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R1 unexpected done got=1 exp=0");
            end else begin
                e = exp_q.pop_front();
                check(e.tag, "found", found_o, e.found);
                check(e.tag, "prediv", prediv_o, e.pre);
                check(e.tag, "fbdiv", fbdiv_o, e.fb);
                check(e.tag, "rate", rate_o, e.rate);
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired got=running exp=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check("R8", "busy", busy_o, 0);
        check("R8", "done", done_o, 0);
        check("R8", "found", found_o, 0);
        check("R8", "prediv", prediv_o, 0);
        check("R8", "fbdiv", fbdiv_o, 0);
        check("R8", "rate", rate_o, 0);

        issue(24_000_000, 500_000_000, "R2 R6 exact fit");          wait_done();
        issue(24_000_000, 187_500_000, "R5 tie keeps low prediv");  wait_done();
        issue(41_000_000, 250_000_000, "R3 window starts at 2");    wait_done();
        issue(7_000_000, 54_000_000, "R4 R7 fb 15 hole");           wait_done();
        issue(5_000_000, 1_277_500_000, "R4 fb 511 legal");         wait_done();
        issue(5_000_000, 1_280_000_000, "R4 R7 fb 512 illegal");    wait_done();
        issue(5_000_000, 30_000_000, "R4 fb 12 legal");             wait_done();
        issue(5_000_000, 27_500_000, "R4 R7 fb 11 illegal");        wait_done();
        issue(4_000_000, 100_000_000, "R3 R7 fref below window");   wait_done();
        issue(0, 100_000_000, "R3 R7 zero fref");                   wait_done();
        issue(200_000_000, 594_000_000, "R2 R5 wide sweep");        wait_done();

        // R1: a start while busy must be ignored
        issue(26_000_000, 445_500_000, "R1 busy ignore");
        fref_i = 32'd24_000_000;
        rate_i = 32'd500_000_000;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R1", "still busy", busy_o, 1);
        wait_done();

        // R9: new start in the done cycle
        issue(19_200_000, 312_000_000, "R9 first");
        wait_done();
        issue(38_400_000, 800_000_000, "R9 second");
        wait_done();

        repeat (4) @(negedge clk);
        check("R1", "done count", dones, issued);
        check("R1", "queue empty", exp_q.size(), 0);
        summary();
    end

endmodule